// File: doc/BRIEF.md
# Byte-Wide Boot Loader Engine

This engine fills internal 24-bit program RAM from an external boot memory that is only eight bits wide. The boot space holds 64K bytes in eight pages of 8K bytes each. A 3-bit page setting picks the page to copy. For every byte the engine forms the boot address and raises the boot select and the read strobe for a programmable number of wait states. It then captures the byte. Each group of three bytes becomes one program word, which the engine writes into RAM at consecutive word addresses.

A load starts in one of two ways. If the map-select input is low when reset is released, a load of page 0 starts by itself. Software can also start a load by setting the force bit through the control write port. A control write also sets the page and the wait-state count. The core stays stalled for the whole load. When the last word has been written, the engine gives a one-cycle done pulse, releases the stall and clears the force bit. The word count is the parameter `WORDS`.

Top module: `byteBootLoader`

## Requirements
- R1: After reset, the wait-state setting is 7, the page setting is 0 and the force bit reads 0. `bootSel`, `bootRd`, `ramWe` and `bootDone` are all low.
- R2: If `mapSel` is 0 at reset release, a load of page 0 starts by itself. If `mapSel` is 1, no load starts: `bootSel` and `ramWe` stay low and `coreStall` stays low.
- R3: A control write with `ctlForce`=1 starts a load of the page value written. `bootForce` reads 1 from the cycle after the write until the done pulse, and reads 0 in the cycle after `bootDone`. Writing `ctlForce`=0 does not clear the force bit.
- R4: For each byte, `bootSel` and `bootRd` stay high for exactly W+1 consecutive cycles, where W (0 to 7) is the wait-state setting. Both strobes then drop for one cycle before the next byte.
- R5: The 16-bit boot address is {page[2:0], offset[12:0]}. Bits 13:0 appear on `bootAddr` and bits 15:14 appear on `dataHi`. Byte k (k = 0, 1, 2) of word n is read at offset 3n+k.
- R6: Bytes are packed most significant first, so word n = {byte0, byte1, byte2}. Word n is written with `ramWe` high at `ramAddr` = n, for n = 0 to WORDS-1, in ascending order.
- R7: `bootDone` is high for exactly one cycle, in the cycle after the last word is written. `coreStall` is high from the cycle a load is requested until that done cycle, and is low in the done cycle.
- R8: `bootRd` is never high while `bootSel` is low.
- R9: Writing a new page setting while a load runs has no effect on that load. All of its bytes still come from the page latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapSel | input | 1 | Memory map select; 0 enables the automatic load at reset release |
| ctlWe | input | 1 | Control register write strobe |
| ctlPage | input | 3 | Page setting written by `ctlWe` |
| ctlWait | input | 3 | Wait-state setting written by `ctlWe` |
| ctlForce | input | 1 | When 1 during a write, sets the force bit |
| bootData | input | 8 | Byte returned by the boot memory |
| bootAddr | output | 14 | Boot address bits 13:0 |
| dataHi | output | 2 | Boot address bits 15:14, driven on the top data lines |
| bootSel | output | 1 | Boot memory select |
| bootRd | output | 1 | Boot memory read strobe |
| ramWe | output | 1 | Program RAM write enable |
| ramAddr | output | 11 | Program RAM word address |
| ramData | output | 24 | Packed program word |
| bootDone | output | 1 | One-cycle pulse at the end of a load |
| coreStall | output | 1 | Holds the core while a load is pending or running |
| bootForce | output | 1 | Current force bit |

## Verification
The hardest case to reach is a control write that lands in the middle of a load and changes the page register while bytes are still being fetched. The stimulus counts a fixed number of cycles into a forced load of page 7, then writes page 2. The scoreboard still expects every word from page 7. The boot memory model derives each byte from the full 16-bit address rebuilt from `dataHi` and `bootAddr`, so a wrong page, wrong top bits or wrong offset shows up as a data mismatch. Strobe lengths are measured against the programmed wait count, both for the reset default of 7 and for settings of 0 and 3.

// File: rtl/bootLdrPkg.sv
package bootLdrPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_NEXT, ST_DONE} bootState_e;

  typedef struct packed {
    logic start;
    logic capture;
    logic writeWord;
  } bootStrobe_t;
endpackage

// File: rtl/bootLdrCtl.sv
module bootLdrCtl
  import bootLdrPkg::*;
#(
  parameter int WAITW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mapSel,
  input  logic             ctlWe,
  input  logic             ctlForce,
  input  logic [WAITW-1:0] ctlWait,
  input  logic             wordFull,
  input  logic             lastWord,
  output bootStrobe_t      strb,
  output logic             bootSel,
  output logic             bootRd,
  output logic             bootDone,
  output logic             coreStall,
  output logic             forceBit
);
  localparam logic [WAITW-1:0] WAIT_RESET = {WAITW{1'b1}};

  bootState_e       state, stateNext;
  logic [WAITW-1:0] waitReg, waitCnt;
  logic             autoReq, forceReg, startReq, loadCnt;

  assign startReq = (autoReq & ~mapSel) | forceReg;

  always_comb begin
    stateNext = state;
    strb      = '0;
    loadCnt   = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        strb.start = 1'b1;
        loadCnt    = 1'b1;
        stateNext  = ST_READ;
      end
      ST_READ: if (waitCnt == '0) begin
        strb.capture = 1'b1;
        stateNext    = ST_NEXT;
      end
      ST_NEXT: begin
        strb.writeWord = wordFull;
        if (wordFull && lastWord) stateNext = ST_DONE;
        else begin
          loadCnt   = 1'b1;
          stateNext = ST_READ;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitReg  <= WAIT_RESET;
      waitCnt  <= '0;
      autoReq  <= 1'b1;
      forceReg <= 1'b0;
    end else begin
      state   <= stateNext;
      autoReq <= 1'b0;
      if (ctlWe) waitReg <= ctlWait;
      if (loadCnt) waitCnt <= waitReg;
      else if (state == ST_READ && waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      if (state == ST_DONE) forceReg <= 1'b0;
      else if (ctlWe && ctlForce) forceReg <= 1'b1;
    end
  end

  assign bootSel   = (state == ST_READ);
  assign bootRd    = (state == ST_READ);
  assign bootDone  = (state == ST_DONE);
  assign forceBit  = forceReg;
  assign coreStall = (state == ST_READ) || (state == ST_NEXT) ||
                     ((state == ST_IDLE) && startReq);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !bootDone); // R7
  AST_FORCE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !forceBit); // R3
  AST_NO_STALL_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> !coreStall); // R7
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (bootRd && $past(bootRd)) |-> (waitCnt < $past(waitCnt))); // R4
endmodule

// File: rtl/bootLdrDp.sv
module bootLdrDp
  import bootLdrPkg::*;
#(
  parameter int WORDS = 2048,
  parameter int PAGEW = 3,
  parameter int OFFW  = 13,
  parameter int HIW   = 2,
  parameter int BYTEW = 8,
  parameter int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ctlWe,
  input  logic [PAGEW-1:0]       ctlPage,
  input  logic [BYTEW-1:0]       bootData,
  input  bootStrobe_t            strb,
  output logic [PAGEW+OFFW-HIW-1:0] bootAddr,
  output logic [HIW-1:0]         dataHi,
  output logic                   ramWe,
  output logic [AW-1:0]          ramAddr,
  output logic [3*BYTEW-1:0]     ramData,
  output logic                   wordFull,
  output logic                   lastWord
);
  localparam int ADDRW = PAGEW + OFFW;
  localparam int WORDW = 3 * BYTEW;
  localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

  logic [PAGEW-1:0] pageReg, pageLat;
  logic [OFFW-1:0]  offset;
  logic [1:0]       byteIdx;
  logic [WORDW-1:0] shiftReg;
  logic [AW-1:0]    wordCnt;
  logic [ADDRW-1:0] fullAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg  <= '0;
      pageLat  <= '0;
      offset   <= '0;
      byteIdx  <= '0;
      shiftReg <= '0;
      wordCnt  <= '0;
      wordFull <= 1'b0;
    end else begin
      if (ctlWe) pageReg <= ctlPage;
      if (strb.start) begin
        pageLat  <= pageReg;
        offset   <= '0;
        byteIdx  <= '0;
        wordCnt  <= '0;
        wordFull <= 1'b0;
      end else if (strb.capture) begin
        shiftReg <= {shiftReg[WORDW-BYTEW-1:0], bootData};
        offset   <= offset + 1'b1;
        byteIdx  <= (byteIdx == 2'd2) ? 2'd0 : byteIdx + 2'd1;
        wordFull <= (byteIdx == 2'd2);
      end else if (strb.writeWord) begin
        wordCnt  <= wordCnt + 1'b1;
        wordFull <= 1'b0;
      end
    end
  end

  assign fullAddr = {pageLat, offset};
  assign bootAddr = fullAddr[ADDRW-HIW-1:0];
  assign dataHi   = fullAddr[ADDRW-1:ADDRW-HIW];
  assign ramWe    = strb.writeWord;
  assign ramAddr  = wordCnt;
  assign ramData  = shiftReg;
  assign lastWord = (wordCnt == LAST_IDX);

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (byteIdx == 2'd0)); // R6
  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (int'(ramAddr) < WORDS)); // R6
  AST_OFFSET_IN_IMAGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (int'(offset) < 3 * WORDS)); // R5
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.start && $past(!strb.start)) |-> $stable(pageLat)); // R9
endmodule

// File: rtl/byteBootLoader.sv
module byteBootLoader
  import bootLdrPkg::*;
#(
  parameter int WORDS = 2048,
  parameter int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          mapSel,
  input  logic          ctlWe,
  input  logic [2:0]    ctlPage,
  input  logic [2:0]    ctlWait,
  input  logic          ctlForce,
  input  logic [7:0]    bootData,
  output logic [13:0]   bootAddr,
  output logic [1:0]    dataHi,
  output logic          bootSel,
  output logic          bootRd,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [23:0]   ramData,
  output logic          bootDone,
  output logic          coreStall,
  output logic          bootForce
);
  bootStrobe_t strb;
  logic        wordFull, lastWord;

  bootLdrCtl #(.WAITW(3)) uCtl (
    .clk(clk), .rstN(rstN), .mapSel(mapSel), .ctlWe(ctlWe),
    .ctlForce(ctlForce), .ctlWait(ctlWait), .wordFull(wordFull),
    .lastWord(lastWord), .strb(strb), .bootSel(bootSel), .bootRd(bootRd),
    .bootDone(bootDone), .coreStall(coreStall), .forceBit(bootForce)
  );

  bootLdrDp #(.WORDS(WORDS), .PAGEW(3), .OFFW(13), .HIW(2), .BYTEW(8), .AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlPage(ctlPage),
    .bootData(bootData), .strb(strb), .bootAddr(bootAddr), .dataHi(dataHi),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .wordFull(wordFull), .lastWord(lastWord)
  );

  AST_SEL_STALLS_CORE: assert property (@(posedge clk) disable iff (!rstN)
    bootSel |-> coreStall); // R7
  AST_WRITE_STALLS_CORE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (coreStall && !bootSel)); // R4
endmodule

// File: tb/sim_byteBootLoader.sv
module sim_byteBootLoader;
  localparam int WORDS = 6;
  localparam int AW = $clog2(WORDS);

  logic clk = 1'b0, rstN = 1'b0, mapSel = 1'b0, ctlWe = 1'b0, ctlForce = 1'b0;
  logic [2:0] ctlPage = '0, ctlWait = '0;
  logic [7:0] bootData;
  logic [13:0] bootAddr;
  logic [1:0] dataHi;
  logic bootSel, bootRd, ramWe, bootDone, coreStall, bootForce;
  logic [AW-1:0] ramAddr;
  logic [23:0] ramData;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [2:0] expPage = 3'd0;
  int expWait = 7;
  int runLen = 0;
  logic [31:0] sbq[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
  endfunction

  assign bootData = memByte({dataHi, bootAddr});

  byteBootLoader #(.WORDS(WORDS)) u0 (
    .clk(clk), .rstN(rstN), .mapSel(mapSel), .ctlWe(ctlWe), .ctlPage(ctlPage),
    .ctlWait(ctlWait), .ctlForce(ctlForce), .bootData(bootData),
    .bootAddr(bootAddr), .dataHi(dataHi), .bootSel(bootSel), .bootRd(bootRd),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData), .bootDone(bootDone),
    .coreStall(coreStall), .bootForce(bootForce)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected words for one load
  task automatic pushWords(input logic [2:0] pg);
    for (int n = 0; n < WORDS; n++) begin
      logic [23:0] w;
      for (int k = 0; k < 3; k++)
        w = {w[15:0], memByte({pg, 13'(3 * n + k)})};
      sbq.push_back({8'(n), w});
    end
  endtask

  // monitor side: compares writes, strobe lengths and top address bits
  always @(negedge clk) begin
    if (rstN) begin
      if (ramWe) begin
        if (sbq.size() == 0) check(0, "R2 unexpected write", int'(ramAddr), 0);
        else begin
          logic [31:0] e;
          e = sbq.pop_front();
          check(ramAddr == e[31:24], "R6 word address", int'(ramAddr), int'(e[31:24]));
          check(ramData == e[23:0], "R5/R6 packed word", int'(ramData), int'(e[23:0]));
        end
      end
      if (bootRd && !bootSel) check(0, "R8 read without select", 1, 0);
      if (bootSel) begin
        if (dataHi != expPage[2:1]) check(0, "R5 top address bits", int'(dataHi), int'(expPage[2:1]));
        runLen++;
      end else if (runLen > 0) begin
        check(runLen == expWait + 1, "R4 strobe length", runLen, expWait + 1);
        runLen = 0;
      end
    end else runLen = 0;
  end

  task automatic ctlWrite(input logic [2:0] pg, input logic [2:0] wt, input logic fc);
    @(negedge clk);
    ctlWe = 1'b1; ctlPage = pg; ctlWait = wt; ctlForce = fc;
    @(negedge clk);
    ctlWe = 1'b0; ctlForce = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n;
    n = 0;
    while (!bootDone && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(bootDone, {tag, " done seen"}, int'(bootDone), 1);
    check(!coreStall, "R7 stall released at done", int'(coreStall), 0);
    check(sbq.size() == 0, {tag, " all words written"}, sbq.size(), 0);
    @(negedge clk);
    check(!bootDone, "R7 done single cycle", int'(bootDone), 0);
    check(!bootForce, "R3 force cleared after done", int'(bootForce), 0);
    check(!coreStall, "R7 stall low after done", int'(coreStall), 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    // R1 reset state, R2 auto-load of page 0
    mapSel = 1'b0;
    expPage = 3'd0; expWait = 7;
    pushWords(3'd0);
    repeat (3) @(negedge clk);
    check(!bootSel && !bootRd, "R1 strobes low in reset", int'(bootSel), 0);
    check(!ramWe && !bootDone, "R1 write and done low in reset", int'(ramWe), 0);
    check(!bootForce, "R1 force bit zero", int'(bootForce), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(coreStall, "R2 stall after auto start", int'(coreStall), 1);
    check(bootSel, "R2 auto load started", int'(bootSel), 1);
    waitDone("R2");

    // R2 no load when map select is 1
    rstN = 1'b0; mapSel = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    begin
      int seen;
      seen = 0;
      repeat (60) begin
        @(negedge clk);
        if (bootSel || coreStall) seen++;
      end
      check(seen == 0, "R2 no load with map select 1", seen, 0);
    end

    // R3 forced load of page 5 with zero wait states
    expPage = 3'd5; expWait = 0;
    pushWords(3'd5);
    ctlWrite(3'd5, 3'd0, 1'b1);
    check(bootForce, "R3 force bit set", int'(bootForce), 1);
    check(coreStall, "R3 stall during forced load", int'(coreStall), 1);
    waitDone("R3");

    // R9 page changed mid-load; R4 three wait states; R3 write of zero keeps force
    expPage = 3'd7; expWait = 3;
    pushWords(3'd7);
    ctlWrite(3'd7, 3'd3, 1'b1);
    repeat (20) @(negedge clk);
    ctlWrite(3'd2, 3'd3, 1'b0);
    check(bootForce, "R3 force kept after zero write", int'(bootForce), 1);
    waitDone("R9");

    // page 2 from the register written mid-load (top bits 01)
    expPage = 3'd2;
    pushWords(3'd2);
    ctlWrite(3'd2, 3'd3, 1'b1);
    waitDone("R5");

    repeat (3) @(negedge clk);
    finish();
  end
endmodule